// File: doc/BRIEF.md
# Full-Duplex Pause Flow Controller

This block runs both halves of standard full-duplex pause flow control for a single switch port. Toward the port's own transmitter it keeps a pause timer. A received pause indication loads the timer with its quanta value. An external tick, one pulse per quantum of 512 bit times, counts the timer down. While the timer is non-zero, no new normal frame may start. A normal frame that is already on the wire runs to its end. Pause frames that this device generates are never held back.

Toward the link partner it watches how much room the destination resource has for frames arriving on this port. When the free count drops below a low watermark, the block asks the transmitter for one XOFF frame carrying the largest pause value. It then waits until the free count climbs above a high watermark, and asks for one XON frame carrying zero. The gap between the two marks keeps the mechanism from flapping. A single enable input switches both directions off.

Top module: `pause_flow_ctrl`

## Requirements
- R1: When enabled, a pause strobe loads the timer with its 16-bit value at that clock edge. `rx_paused` is high from the next cycle when the value is non-zero, and low from the next cycle when the value is zero.
- R2: Each quanta tick lowers a non-zero timer by one. `rx_paused` drops in the cycle after the tick that brings the timer to zero. A strobe and a tick in the same cycle load the strobe's value, and the tick is lost.
- R3: A strobe that arrives while the timer is still running replaces the remaining count with the new value. The remaining count is not added to.
- R4: `tx_norm_go` equals `tx_norm_req` AND NOT `rx_paused` AND NOT `tx_norm_busy` AND NOT `tx_ctl_req`, within the same cycle. A pending pause-frame request therefore wins over a normal frame start.
- R5: `tx_norm_busy` rises the cycle after `tx_norm_go` and stays high until the cycle after `tx_norm_done`. A pause arriving meanwhile does not clear it.
- R6: `tx_ctl_req` is never gated by `rx_paused`. Generated pause frames are requested while the port is paused.
- R7: With enable high and no episode open, a free count strictly below LOW_MARK raises `tx_ctl_req` in the next cycle, with `tx_ctl_quanta` = 0xFFFF.
- R8: `tx_ctl_req` stays high until `tx_ctl_ack`, and drops the cycle after the ack. Only one XOFF is requested per episode, however long the free count stays low.
- R9: After the XOFF is acknowledged, free counts from LOW_MARK to HIGH_MARK inclusive cause no request. A count strictly above HIGH_MARK raises `tx_ctl_req` in the next cycle with `tx_ctl_quanta` = 0. The ack of that XON closes the episode.
- R10: While `en` is low, `rx_paused` is low, pause strobes are ignored, the timer is cleared, no request is raised, and any open episode is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Flow control enable for both directions |
| rx_pause_vld | input | 1 | Received pause frame strobe |
| rx_pause_quanta | input | 16 | Pause value of the received frame |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| rx_paused | output | 1 | Port transmitter is held by the partner |
| tx_norm_req | input | 1 | Transmitter wants to start a normal frame |
| tx_norm_done | input | 1 | Current normal frame has ended |
| tx_norm_go | output | 1 | Permission to start the normal frame now |
| tx_norm_busy | output | 1 | A normal frame is in progress |
| dst_free | input | FREE_W (10) | Free units in the destination resource |
| tx_ctl_req | output | 1 | Request to send a generated pause frame |
| tx_ctl_quanta | output | 16 | Pause value for the requested frame |
| tx_ctl_ack | input | 1 | Generated pause frame has been taken |

## Verification
The hardest case to reach from the ports is a pause strobe that reloads a running timer in the same cycle as a tick, or just before the old count would have run out. The bench forces it by loading a short value, ticking it almost to zero and then reloading. A random phase then fires frequent strobes and ticks together. The other delicate case is an XOFF left unacknowledged while the free count recovers past the high mark. The random phase reaches it by withholding acks for random stretches while the free count jumps across both watermarks.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int PFC_QUANTA_W = 16;
  localparam logic [PFC_QUANTA_W-1:0] PFC_QUANTA_MAX = '1;

  typedef enum logic [1:0] {
    WM_OPEN      = 2'd0,
    WM_XOFF_PEND = 2'd1,
    WM_HELD      = 2'd2,
    WM_XON_PEND  = 2'd3
  } wm_state_e;

  // Next pause timer value: a load wins over a tick, and the count stops at zero.
  function automatic logic [PFC_QUANTA_W-1:0] timer_next(
    input logic [PFC_QUANTA_W-1:0] cur,
    input logic                    load,
    input logic [PFC_QUANTA_W-1:0] load_val,
    input logic                    tick
  );
    if (load)                return load_val;
    if (tick && (cur != '0)) return cur - 1'b1;
    return cur;
  endfunction

  function automatic logic is_below(input int unsigned level, input int unsigned mark);
    return level < mark;
  endfunction

  function automatic logic is_above(input int unsigned level, input int unsigned mark);
    return level > mark;
  endfunction

endpackage

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer
  import pfc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    load,
  input  logic [PFC_QUANTA_W-1:0] load_val,
  input  logic                    tick,
  output logic                    paused
);

  logic [PFC_QUANTA_W-1:0] cnt_q;
  logic                    load_ok;

  assign load_ok = en & load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= timer_next(cnt_q, load_ok, load_val, tick);
  end

  assign paused = en & (cnt_q != '0);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (cnt_q == $past(load_val))); // R1
  AST_TICK_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !tick) |=> $stable(cnt_q)); // R2
  AST_RELOAD_OVERWRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && cnt_q != '0) |=> (cnt_q == $past(load_val))); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/pfc_tx_gate.sv
module pfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic paused,
  input  logic ctl_pending,
  input  logic norm_req,
  input  logic norm_done,
  output logic norm_go,
  output logic norm_busy
);

  logic busy_q;

  assign norm_go = norm_req & ~paused & ~busy_q & ~ctl_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (norm_go)   busy_q <= 1'b1;
    else if (norm_done) busy_q <= 1'b0;
  end

  assign norm_busy = busy_q;

  AST_NO_START_WHILE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    norm_go |-> !paused); // R4
  AST_CTL_BEFORE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    norm_go |-> !ctl_pending); // R4
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    norm_go |=> norm_busy); // R5
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_busy && !norm_done) |=> norm_busy); // R5

endmodule

// File: rtl/pfc_wm_ctrl.sv
module pfc_wm_ctrl
  import pfc_pkg::*;
#(
  parameter int FREE_W    = 10,
  parameter int LOW_MARK  = 64,
  parameter int HIGH_MARK = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [FREE_W-1:0]       free_cnt,
  input  logic                    ack,
  output logic                    req,
  output logic [PFC_QUANTA_W-1:0] quanta
);

  wm_state_e st_q, st_d;
  logic      low_hit, high_hit;

  assign low_hit  = is_below(32'(free_cnt), LOW_MARK);
  assign high_hit = is_above(32'(free_cnt), HIGH_MARK);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WM_OPEN:      if (low_hit)  st_d = WM_XOFF_PEND;
      WM_XOFF_PEND: if (ack)      st_d = WM_HELD;
      WM_HELD:      if (high_hit) st_d = WM_XON_PEND;
      WM_XON_PEND:  if (ack)      st_d = WM_OPEN;
      default:                    st_d = WM_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= WM_OPEN;
    else if (!en) st_q <= WM_OPEN;
    else          st_q <= st_d;
  end

  assign req    = en & ((st_q == WM_XOFF_PEND) | (st_q == WM_XON_PEND));
  assign quanta = (st_q == WM_XOFF_PEND) ? PFC_QUANTA_MAX : '0;

  AST_XOFF_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == WM_OPEN && free_cnt < FREE_W'(LOW_MARK)) |=>
      (!en || (req && quanta == PFC_QUANTA_MAX))); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && en) |=> (req || !en)); // R8
  AST_ONE_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && quanta == PFC_QUANTA_MAX) |=> !req); // R8
  AST_XON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == WM_HELD && high_hit) |=> (!en || (req && quanta == '0))); // R9
  AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == WM_OPEN)); // R10

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int FREE_W    = 10,
  parameter int LOW_MARK  = 64,
  parameter int HIGH_MARK = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    rx_pause_vld,
  input  logic [PFC_QUANTA_W-1:0] rx_pause_quanta,
  input  logic                    quanta_tick,
  output logic                    rx_paused,
  input  logic                    tx_norm_req,
  input  logic                    tx_norm_done,
  output logic                    tx_norm_go,
  output logic                    tx_norm_busy,
  input  logic [FREE_W-1:0]       dst_free,
  output logic                    tx_ctl_req,
  output logic [PFC_QUANTA_W-1:0] tx_ctl_quanta,
  input  logic                    tx_ctl_ack
);

  logic paused_w;
  logic ctl_req_w;

  pfc_pause_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (rx_pause_vld),
    .load_val (rx_pause_quanta),
    .tick     (quanta_tick),
    .paused   (paused_w)
  );

  pfc_tx_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .paused      (paused_w),
    .ctl_pending (ctl_req_w),
    .norm_req    (tx_norm_req),
    .norm_done   (tx_norm_done),
    .norm_go     (tx_norm_go),
    .norm_busy   (tx_norm_busy)
  );

  pfc_wm_ctrl #(
    .FREE_W    (FREE_W),
    .LOW_MARK  (LOW_MARK),
    .HIGH_MARK (HIGH_MARK)
  ) u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .free_cnt (dst_free),
    .ack      (tx_ctl_ack),
    .req      (ctl_req_w),
    .quanta   (tx_ctl_quanta)
  );

  assign rx_paused  = paused_w;
  assign tx_ctl_req = ctl_req_w;

  AST_CTL_NOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ctl_req && !tx_ctl_ack && en) |=> (tx_ctl_req || !en)); // R6

endmodule

// File: tb/pause_flow_ctrl_tb_top.sv
module pause_flow_ctrl_tb_top;

  localparam int FW = 10;
  localparam int LOWM = 64;
  localparam int HIGHM = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pv = 1'b0, tick = 1'b0, nreq = 1'b0, ndone = 1'b0, ack = 1'b0;
  logic [15:0] pval = '0;
  logic [FW-1:0] free = 10'd500;
  logic paused, go, busy, creq;
  logic [15:0] cq;

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 1'b0;

  // reference model state
  int unsigned m_cnt = 0;
  int m_st = 0; // 0 open, 1 xoff pending, 2 held, 3 xon pending
  bit m_busy = 1'b0;

  always #5 clk = ~clk;

  pause_flow_ctrl #(.FREE_W(FW), .LOW_MARK(LOWM), .HIGH_MARK(HIGHM)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_pause_vld(pv), .rx_pause_quanta(pval),
    .quanta_tick(tick), .rx_paused(paused), .tx_norm_req(nreq), .tx_norm_done(ndone),
    .tx_norm_go(go), .tx_norm_busy(busy), .dst_free(free), .tx_ctl_req(creq),
    .tx_ctl_quanta(cq), .tx_ctl_ack(ack)
  );

  function automatic bit f_paused();
    return en && (m_cnt != 0);
  endfunction
  function automatic bit f_creq();
    return en && (m_st == 1 || m_st == 3);
  endfunction
  function automatic int unsigned f_cq();
    return (m_st == 1) ? 32'hFFFF : 32'h0;
  endfunction
  function automatic bit f_go();
    return nreq && !f_paused() && !m_busy && !f_creq();
  endfunction

  task automatic chk(input string r, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // reference model advances on each edge from the inputs held over that cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_busy = 1'b0;
    end else begin
      bit g;
      g = f_go();
      if (g) m_busy = 1'b1;
      else if (ndone) m_busy = 1'b0;
      if (!en) begin
        m_cnt = 0; m_st = 0;
      end else begin
        if (pv) m_cnt = pval;
        else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
        case (m_st)
          0: if (free < LOWM) m_st = 1;
          1: if (ack) m_st = 2;
          2: if (free > HIGHM) m_st = 3;
          default: if (ack) m_st = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      chk("R2 rx_paused vs model", paused, f_paused());
      chk("R4 tx_norm_go vs model", go, f_go());
      chk("R5 tx_norm_busy vs model", busy, m_busy);
      chk("R8 tx_ctl_req vs model", creq, f_creq());
      if (creq) chk("R7 tx_ctl_quanta vs model", cq, f_cq());
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    pv = 1'b0; tick = 1'b0; ndone = 1'b0; ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    chk("R1 reset rx_paused", paused, 0);
    chk("R5 reset tx_norm_busy", busy, 0);
    chk("R8 reset tx_ctl_req", creq, 0);
    en = 1'b1;
    chk_on = 1'b1;

    // R1, R3: load, tick down, reload before expiry
    pv = 1'b1; pval = 16'd5; step(); #1;
    chk("R1 paused after load of 5", paused, 1);
    tick = 1'b1; step(); tick = 1'b1; step();
    pv = 1'b1; pval = 16'd20; tick = 1'b1; step();
    repeat (4) begin tick = 1'b1; step(); end
    #1 chk("R3 reload keeps port paused past old expiry", paused, 1);
    pv = 1'b1; pval = 16'd0; step(); #1;
    chk("R1 zero pause value releases", paused, 0);

    // R2: count to zero exactly
    pv = 1'b1; pval = 16'd2; step();
    tick = 1'b1; step(); #1 chk("R2 one quantum left", paused, 1);
    tick = 1'b1; step(); #1 chk("R2 released at zero", paused, 0);

    // R5: frame in progress survives a pause
    nreq = 1'b1; #1 chk("R4 start allowed when idle", go, 1);
    step(); nreq = 1'b0;
    pv = 1'b1; pval = 16'd9; step(); #1;
    chk("R5 busy kept while pause arrives", busy, 1);
    chk("R1 paused during frame", paused, 1);
    ndone = 1'b1; step();
    nreq = 1'b1; #1 chk("R4 no start while paused", go, 0);
    pv = 1'b1; pval = 16'd0; step(); #1;
    chk("R4 start after release", go, 1);
    step(); nreq = 1'b0; ndone = 1'b1; step();

    // R6, R7, R8, R9: XOFF while paused, hysteresis, XON
    pv = 1'b1; pval = 16'd100; free = 10'd10; step(); #1;
    chk("R6 request while paused", creq, 1);
    chk("R7 XOFF carries max quanta", cq, 16'hFFFF);
    nreq = 1'b1; #1 chk("R4 control request blocks start", go, 0);
    nreq = 1'b0;
    repeat (3) step();
    #1 chk("R8 request held without ack", creq, 1);
    ack = 1'b1; step(); #1 chk("R8 dropped after ack", creq, 0);
    repeat (5) step();
    #1 chk("R8 no second XOFF while low", creq, 0);
    free = 10'(LOWM); repeat (3) step();
    free = 10'(HIGHM); repeat (3) step();
    #1 chk("R9 quiet between marks", creq, 0);
    free = 10'(HIGHM + 1); step(); #1;
    chk("R9 XON requested above high mark", creq, 1);
    chk("R9 XON carries zero", cq, 0);
    ack = 1'b1; step(); #1 chk("R9 episode closed", creq, 0);

    // R10: disabled
    en = 1'b0; #1 chk("R10 paused drops with enable", paused, 0);
    pv = 1'b1; pval = 16'd50; step(); #1;
    chk("R10 strobe ignored", paused, 0);
    free = 10'd5; repeat (3) step();
    #1 chk("R10 no request when disabled", creq, 0);
    free = 10'd500; en = 1'b1; step();
    #1 chk("R10 timer cleared while disabled", paused, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      en    = ($urandom % 64) != 0;
      pv    = ($urandom % 12) == 0;
      pval  = (($urandom % 5) == 0) ? 16'd0 : 16'($urandom % 40);
      tick  = ($urandom % 3) == 0;
      nreq  = ($urandom % 2) == 0;
      ndone = ($urandom % 4) == 0;
      ack   = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) free = 10'($urandom % 260);
      step();
    end
    nreq = 1'b0;
    step();
    chk_on = 1'b0;
    finish_run();
  end

endmodule